// File: doc/BRIEF.md
# Processor Status Register with Reset-Cause Flags

This block holds the 8-bit status word of a small processor core. It keeps the three arithmetic flags (carry, digit carry, zero), a pair of reset-cause flags (time-out and power-down), two program-page select bits and one spare bit. Several sources update the word at once:

- an instruction-side write with a per-bit mask;
- per-flag strobes from the ALU;
- pulses from the sleep and watchdog logic;
- a synchronous reset request that carries a type code.

Instructions can never touch the time-out and power-down flags. Those two flags change only through hardware events and reset, so after a reset firmware can read the pair and tell why the core restarted. The page bits form the upper program-address bits. A parameter selects either a four-page build or a two-page build.

Top module: `cpu_status_reg`

## Requirements
- R1: Bit positions in `statusOut` are fixed: bit 0 carry, bit 1 digit carry, bit 2 zero, bit 3 power-down (PD), bit 4 time-out (TO), bit 5 page select 0, bit 6 page select 1, bit 7 spare read/write. The register updates on the rising clock edge and is seen on `statusOut` from the next cycle.
- R2: A reset request with `rstKind` = 2'b00 (power-on) loads TO=1 and PD=1 and clears bits 7:5. The arithmetic flags read 0 but carry no defined meaning.
- R3: A reset request of any other kind clears bits 7:5 and keeps bits 2:0. Kind 2'b01 (watchdog) clears TO and keeps PD. Kinds 2'b10 (external pin) and 2'b11 keep both TO and PD. During any reset cycle the instruction write, ALU strobes and event pulses have no effect.
- R4: When `wrEn` is high, each bit whose `wrMask` bit is 1 takes the matching `wrData` bit, and unmasked bits hold. TO and PD never change through this port.
- R5: An ALU strobe (`aluCarryEn`, `aluDcEn`, `aluZeroEn`) loads its flag value in the same cycle and wins over the instruction write to that bit. A clear of the register (mask 8'hE7, data 0, zero strobe with value 1) therefore yields `000UU100`.
- R6: A watchdog-clear pulse sets TO=1 and PD=1.
- R7: A sleep pulse sets TO=1 and PD=0. It wins over a watchdog-clear pulse in the same cycle.
- R8: A watchdog-overflow pulse sets TO=0 and keeps PD. It wins over sleep and watchdog-clear pulses in the same cycle.
- R9: An event pulse and an instruction write in the same cycle both take effect. The event sets TO/PD and the write sets the other bits.
- R10: With NUM_PAGES=4, `progAddrHi` equals {PA1, PA0}. With NUM_PAGES=2, `progAddrHi` equals {0, PA0}, and PA1 is a plain read/write bit.
- R11: The TO/PD pair after a warm reset tells the cause: sleep then watchdog reset gives 00, watchdog reset while awake gives 01, and sleep then pin reset gives 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstReq | input | 1 | Synchronous reset request |
| rstKind | input | 2 | Reset type: 00 power-on, 01 watchdog, 10/11 external pin |
| wrEn | input | 1 | Instruction write enable |
| wrMask | input | 8 | Per-bit write mask |
| wrData | input | 8 | Write data |
| aluCarryEn | input | 1 | Carry update strobe |
| aluCarry | input | 1 | Carry value |
| aluDcEn | input | 1 | Digit-carry update strobe |
| aluDc | input | 1 | Digit-carry value |
| aluZeroEn | input | 1 | Zero update strobe |
| aluZero | input | 1 | Zero value |
| evSleep | input | 1 | Sleep event pulse |
| evWdtClr | input | 1 | Watchdog-clear event pulse |
| evWdtOvf | input | 1 | Watchdog-overflow event pulse |
| statusOut | output | 8 | Status register value |
| progAddrHi | output | 2 | Program address bits 10:9 |

## Verification
An instruction write and a hardware event can land in the same cycle. So can an instruction write and an ALU strobe aimed at the same bit. Random stimulus raises the write enable, the ALU strobes and the event pulses independently, so these overlaps occur often. Directed cases add the register-clear pattern and an event combined with a full-byte write. Each result is judged bit by bit against a bench model: event bits come from the event priority, strobed bits from the ALU, and the remaining masked bits from the write data.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;

  localparam int STAT_W = 8;
  localparam int BIT_C  = 0;
  localparam int BIT_DC = 1;
  localparam int BIT_Z  = 2;
  localparam int BIT_PD = 3;
  localparam int BIT_TO = 4;
  localparam int BIT_P0 = 5;
  localparam int BIT_P1 = 6;
  localparam int BIT_SP = 7;

  typedef enum logic [1:0] {
    RST_POWER = 2'b00,
    RST_WDOG  = 2'b01,
    RST_PIN   = 2'b10,
    RST_PIN2  = 2'b11
  } rst_kind_e;

  // Strobes handed from the control side to the datapath.
  typedef struct packed {
    logic porLoad;
    logic warmLoad;
    logic instrEn;
    logic toWe;
    logic toVal;
    logic pdWe;
    logic pdVal;
  } stat_ctl_t;

endpackage

// File: rtl/cpu_status_ctrl.sv
module cpu_status_ctrl
  import cpu_status_pkg::*;
(
  input  logic       rstReq,
  input  logic [1:0] rstKind,
  input  logic       evSleep,
  input  logic       evWdtClr,
  input  logic       evWdtOvf,
  output stat_ctl_t  ctl
);

  always_comb begin
    ctl          = '0;
    ctl.porLoad  = rstReq && (rstKind == RST_POWER);
    ctl.warmLoad = rstReq && (rstKind != RST_POWER);
    ctl.instrEn  = !rstReq;
    if (rstReq) begin
      if (rstKind == RST_WDOG) begin
        ctl.toWe  = 1'b1;
        ctl.toVal = 1'b0;
      end
    end else if (evWdtOvf) begin
      ctl.toWe  = 1'b1;
      ctl.toVal = 1'b0;
    end else if (evSleep) begin
      ctl.toWe  = 1'b1;
      ctl.toVal = 1'b1;
      ctl.pdWe  = 1'b1;
      ctl.pdVal = 1'b0;
    end else if (evWdtClr) begin
      ctl.toWe  = 1'b1;
      ctl.toVal = 1'b1;
      ctl.pdWe  = 1'b1;
      ctl.pdVal = 1'b1;
    end
  end

endmodule

// File: rtl/cpu_status_dp.sv
module cpu_status_dp
  import cpu_status_pkg::*;
#(
  parameter int NUM_PAGES = 4
) (
  input  logic              clk,
  input  stat_ctl_t         ctl,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrMask,
  input  logic [STAT_W-1:0] wrData,
  input  logic              aluCarryEn,
  input  logic              aluCarry,
  input  logic              aluDcEn,
  input  logic              aluDc,
  input  logic              aluZeroEn,
  input  logic              aluZero,
  output logic [STAT_W-1:0] statQ,
  output logic [1:0]        pageHi
);

  localparam logic [STAT_W-1:0] POR_VAL = STAT_W'((1 << BIT_TO) | (1 << BIT_PD));
  localparam logic [STAT_W-1:0] LOCKED  = STAT_W'((1 << BIT_TO) | (1 << BIT_PD));
  localparam logic [STAT_W-1:0] WARM_CLR = STAT_W'((1 << BIT_P0) | (1 << BIT_P1) | (1 << BIT_SP));

  logic [STAT_W-1:0] wrSel;
  logic [STAT_W-1:0] nxt;

  assign wrSel = (wrEn && ctl.instrEn) ? (wrMask & ~LOCKED) : '0;

  always_comb begin
    nxt = (statQ & ~wrSel) | (wrData & wrSel);
    if (ctl.instrEn) begin
      if (aluCarryEn) nxt[BIT_C]  = aluCarry;
      if (aluDcEn)    nxt[BIT_DC] = aluDc;
      if (aluZeroEn)  nxt[BIT_Z]  = aluZero;
    end
    if (ctl.warmLoad) nxt = nxt & ~WARM_CLR;
    if (ctl.toWe) nxt[BIT_TO] = ctl.toVal;
    if (ctl.pdWe) nxt[BIT_PD] = ctl.pdVal;
  end

  always_ff @(posedge clk) begin
    if (ctl.porLoad) statQ <= POR_VAL;
    else             statQ <= nxt;
  end

  generate
    if (NUM_PAGES == 4) begin : g_four
      assign pageHi = {statQ[BIT_P1], statQ[BIT_P0]};
    end else begin : g_two
      assign pageHi = {1'b0, statQ[BIT_P0]};
    end
  endgenerate

endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import cpu_status_pkg::*;
#(
  parameter int NUM_PAGES = 4
) (
  input  logic       clk,
  input  logic       rstReq,
  input  logic [1:0] rstKind,
  input  logic       wrEn,
  input  logic [7:0] wrMask,
  input  logic [7:0] wrData,
  input  logic       aluCarryEn,
  input  logic       aluCarry,
  input  logic       aluDcEn,
  input  logic       aluDc,
  input  logic       aluZeroEn,
  input  logic       aluZero,
  input  logic       evSleep,
  input  logic       evWdtClr,
  input  logic       evWdtOvf,
  output logic [7:0] statusOut,
  output logic [1:0] progAddrHi
);

  stat_ctl_t ctl;

  cpu_status_ctrl ctrl_i (
    .rstReq   (rstReq),
    .rstKind  (rstKind),
    .evSleep  (evSleep),
    .evWdtClr (evWdtClr),
    .evWdtOvf (evWdtOvf),
    .ctl      (ctl)
  );

  cpu_status_dp #(.NUM_PAGES(NUM_PAGES)) dp_i (
    .clk        (clk),
    .ctl        (ctl),
    .wrEn       (wrEn),
    .wrMask     (wrMask),
    .wrData     (wrData),
    .aluCarryEn (aluCarryEn),
    .aluCarry   (aluCarry),
    .aluDcEn    (aluDcEn),
    .aluDc      (aluDc),
    .aluZeroEn  (aluZeroEn),
    .aluZero    (aluZero),
    .statQ      (statusOut),
    .pageHi     (progAddrHi)
  );

endmodule

// File: rtl/cpu_status_reg_chk.sv
module cpu_status_reg_chk (
  input logic       clk,
  input logic       rstReq,
  input logic [1:0] rstKind,
  input logic       aluZeroEn,
  input logic       aluZero,
  input logic       evSleep,
  input logic       evWdtClr,
  input logic       evWdtOvf,
  input logic [7:0] statusOut
);

  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (rstReq && rstKind == 2'b00) armed <= 1'b1;
  end

  p_por_value_r2: assert property (@(posedge clk) disable iff (!armed)
    (rstReq && rstKind == 2'b00) |=> (statusOut[7:3] == 5'b00011));

  p_warm_keep_r3: assert property (@(posedge clk) disable iff (!armed)
    (rstReq && rstKind != 2'b00) |=>
      (statusOut[7:5] == 3'b000 && statusOut[2:0] == $past(statusOut[2:0])));

  p_locked_bits_r4: assert property (@(posedge clk) disable iff (!armed)
    (!rstReq && !evSleep && !evWdtClr && !evWdtOvf) |=> $stable(statusOut[4:3]));

  p_zero_override_r5: assert property (@(posedge clk) disable iff (!armed)
    (!rstReq && aluZeroEn) |=> (statusOut[2] == $past(aluZero)));

  p_wdt_clear_r6: assert property (@(posedge clk) disable iff (!armed)
    (!rstReq && evWdtClr && !evSleep && !evWdtOvf) |=> (statusOut[4:3] == 2'b11));

  p_sleep_r7: assert property (@(posedge clk) disable iff (!armed)
    (!rstReq && evSleep && !evWdtOvf) |=> (statusOut[4:3] == 2'b10));

  p_wdt_ovf_r8: assert property (@(posedge clk) disable iff (!armed)
    (!rstReq && evWdtOvf) |=> (!statusOut[4] && $stable(statusOut[3])));

endmodule

bind cpu_status_reg cpu_status_reg_chk chk_i (
  .clk       (clk),
  .rstReq    (rstReq),
  .rstKind   (rstKind),
  .aluZeroEn (aluZeroEn),
  .aluZero   (aluZero),
  .evSleep   (evSleep),
  .evWdtClr  (evWdtClr),
  .evWdtOvf  (evWdtOvf),
  .statusOut (statusOut)
);

// File: tb/cpu_status_reg_tb.sv
`timescale 1ns/1ps
module cpu_status_reg_tb_top;

  typedef struct packed {
    logic       rstReq;
    logic [1:0] rstKind;
    logic       wrEn;
    logic [7:0] wrMask;
    logic [7:0] wrData;
    logic       cEn, c, dcEn, dc, zEn, z;
    logic       sl, clr, ovf;
  } stim_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  stim_t cur = '0;
  logic [7:0] statusOut, statusOut2;
  logic [1:0] progAddrHi, progAddrHi2;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ = '0;
  logic [7:0] known = '0;
  bit done = 1'b0;

  cpu_status_reg #(.NUM_PAGES(4)) dut_i (
    .clk(clk), .rstReq(cur.rstReq), .rstKind(cur.rstKind),
    .wrEn(cur.wrEn), .wrMask(cur.wrMask), .wrData(cur.wrData),
    .aluCarryEn(cur.cEn), .aluCarry(cur.c), .aluDcEn(cur.dcEn), .aluDc(cur.dc),
    .aluZeroEn(cur.zEn), .aluZero(cur.z),
    .evSleep(cur.sl), .evWdtClr(cur.clr), .evWdtOvf(cur.ovf),
    .statusOut(statusOut), .progAddrHi(progAddrHi));

  cpu_status_reg #(.NUM_PAGES(2)) dut2_i (
    .clk(clk), .rstReq(cur.rstReq), .rstKind(cur.rstKind),
    .wrEn(cur.wrEn), .wrMask(cur.wrMask), .wrData(cur.wrData),
    .aluCarryEn(cur.cEn), .aluCarry(cur.c), .aluDcEn(cur.dcEn), .aluDc(cur.dc),
    .aluZeroEn(cur.zEn), .aluZero(cur.z),
    .evSleep(cur.sl), .evWdtClr(cur.clr), .evWdtOvf(cur.ovf),
    .statusOut(statusOut2), .progAddrHi(progAddrHi2));

  // Expected next value from the requirements.
  function automatic logic [7:0] modelNext(input logic [7:0] q, input stim_t s);
    logic [7:0] n;
    n = q;
    if (s.rstReq) begin
      if (s.rstKind == 2'b00) return 8'b0001_1000;              // R2
      n[7:5] = 3'b000;                                          // R3
      if (s.rstKind == 2'b01) n[4] = 1'b0;
      return n;
    end
    if (s.wrEn) for (int i = 0; i < 8; i++)
      if (s.wrMask[i] && i != 3 && i != 4) n[i] = s.wrData[i];  // R4
    if (s.cEn)  n[0] = s.c;                                     // R5
    if (s.dcEn) n[1] = s.dc;
    if (s.zEn)  n[2] = s.z;
    if (s.ovf)      n[4] = 1'b0;                                // R8
    else if (s.sl)  begin n[4] = 1'b1; n[3] = 1'b0; end         // R7
    else if (s.clr) begin n[4] = 1'b1; n[3] = 1'b1; end         // R6
    return n;
  endfunction

  function automatic logic [7:0] knownNext(input logic [7:0] k, input stim_t s);
    logic [7:0] n;
    if (s.rstReq && s.rstKind == 2'b00) return 8'hF8;
    n = k;
    if (!s.rstReq) begin
      if (s.wrEn) n = n | s.wrMask;
      if (s.cEn)  n[0] = 1'b1;
      if (s.dcEn) n[1] = 1'b1;
      if (s.zEn)  n[2] = 1'b1;
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Apply one stimulus for one edge, then compare at the falling edge.
  task automatic step(input stim_t s, input string req);
    cur = s;
    expQ  = modelNext(expQ, s);
    known = knownNext(known, s);
    @(posedge clk);
    @(negedge clk);
    cur = '0;
    check(req, statusOut & known, expQ & known);
    check({req, " dut2"}, statusOut2 & known, expQ & known);
    if (known[6:5] == 2'b11) begin
      check("R10 four-page", {6'b0, progAddrHi}, {6'b0, expQ[6:5]});
      check("R10 two-page", {6'b0, progAddrHi2}, {7'b0, expQ[5]});
    end
  endtask

  function automatic stim_t idle();
    return '0;
  endfunction

  function automatic stim_t rst(input logic [1:0] k);
    stim_t s = '0;
    s.rstReq = 1'b1; s.rstKind = k;
    return s;
  endfunction

  function automatic stim_t wr(input logic [7:0] m, input logic [7:0] d);
    stim_t s = '0;
    s.wrEn = 1'b1; s.wrMask = m; s.wrData = d;
    return s;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    stim_t s;
    void'($urandom(32'd5077));
    @(negedge clk);
    // R2: power-on state
    step(rst(2'b00), "R2 power-on");
    check("R2 TO/PD", {6'b0, statusOut[4:3]}, 8'h03);
    check("R2 page+spare", {5'b0, statusOut[7:5]}, 8'h00);
    // R4: full byte write cannot touch TO/PD
    step(wr(8'hFF, 8'h00), "R4 locked bits");
    check("R4 TO/PD kept", {6'b0, statusOut[4:3]}, 8'h03);
    step(wr(8'h60, 8'hFF), "R10 pages 3");
    check("R10 addr", {6'b0, progAddrHi}, 8'h03);
    check("R10 two-page addr", {6'b0, progAddrHi2}, 8'h01);
    check("R1 layout", statusOut, 8'h78);
    // R5: register clear gives 000UU100
    s = wr(8'hE7, 8'h00); s.zEn = 1'b1; s.z = 1'b1;
    step(s, "R5 clear");
    check("R5 clear value", statusOut, 8'b0001_1100);
    // R9: sleep with full write
    s = wr(8'hFF, 8'hA5); s.sl = 1'b1;
    step(s, "R9 event+write");
    check("R9 value", statusOut, 8'hA5 & 8'hE7 | 8'h10);
    // R3/R3: carry kept through a warm reset
    step(rst(2'b10), "R3 pin reset");
    check("R3 keep flags", statusOut, 8'h15);
    // R11 cause codes
    s = idle(); s.sl = 1'b1; step(s, "R11 sleep");
    step(rst(2'b01), "R11 wdt from sleep");
    check("R11 code 00", {6'b0, statusOut[4:3]}, 8'h00);
    s = idle(); s.clr = 1'b1; step(s, "R6 wdt clear");
    check("R6 TO/PD", {6'b0, statusOut[4:3]}, 8'h03);
    step(rst(2'b01), "R11 wdt awake");
    check("R11 code 01", {6'b0, statusOut[4:3]}, 8'h01);
    s = idle(); s.sl = 1'b1; s.clr = 1'b1; step(s, "R7 sleep beats clear");
    check("R7 TO/PD", {6'b0, statusOut[4:3]}, 8'h02);
    step(rst(2'b10), "R11 pin from sleep");
    check("R11 code 10", {6'b0, statusOut[4:3]}, 8'h02);
    s = idle(); s.ovf = 1'b1; s.sl = 1'b1; s.clr = 1'b1; step(s, "R8 overflow wins");
    check("R8 TO/PD", {6'b0, statusOut[4:3]}, 8'h00);
    // R3: reset ignores writes, ALU and events
    s = rst(2'b11); s.wrEn = 1'b1; s.wrMask = 8'hFF; s.wrData = 8'hFF;
    s.zEn = 1'b1; s.z = 1'b1; s.clr = 1'b1;
    step(s, "R3 reset ignores inputs");
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      s = '0;
      s.rstReq  = ($urandom % 20) == 0;
      s.rstKind = 2'($urandom);
      s.wrEn    = $urandom % 2;
      s.wrMask  = 8'($urandom);
      s.wrData  = 8'($urandom);
      s.cEn  = ($urandom % 3) == 0; s.c  = $urandom % 2;
      s.dcEn = ($urandom % 3) == 0; s.dc = $urandom % 2;
      s.zEn  = ($urandom % 3) == 0; s.z  = $urandom % 2;
      s.sl   = ($urandom % 6) == 0;
      s.clr  = ($urandom % 6) == 0;
      s.ovf  = ($urandom % 6) == 0;
      step(s, "R1 random mix");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule